// File: doc/BRIEF.md
# Locality Claim and Release Sequencer

This block claims and hands back the lowest-numbered locality of a trusted platform module that sits behind a simple register bus. It is the bus master for that exchange. A one-cycle `open_i` pulse starts a claim. The block writes the request flag into the locality access register, then reads that register over and over until the device reports the locality as active. It then writes the ready-for-command flag into the status register and finishes.

A one-cycle `close_i` pulse starts a release. The block first reads the access register. If the locality is not active, it finishes without writing anything. If the locality is active, it writes the active flag back to the access register and polls until that flag reads zero.

Every wait is a bounded series of reads. Consecutive reads are `POLL_GAP` cycles apart, and at most `POLL_LIMIT` reads are made; the defaults give 1 µs polls for one second at 125 MHz. When the limit runs out, the operation ends with a timeout. `busy_o` is high while an operation runs. A one-cycle `done_o` marks the end of every operation, and `timeout_o` accompanies it when a wait expired.

Top module: `loc_access_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o` and `bus_req_o` are all low, and no bus transaction takes place until a command pulse arrives.
- R2: An open first writes 0x0000_0002 (bit 1, request use) to the access register at address `BASE_ADDR` + 0x000.
- R3: After the request write, open reads the access register until bit 5 (active) reads 1. After a read that misses, `bus_req_o` stays low for at least `POLL_GAP` cycles before the next read.
- R4: After a read with bit 5 set, open writes 0x0000_0040 (bit 6, command ready) to the status register at `BASE_ADDR` + 0x018 and then finishes without a timeout. That is the only transaction ever sent to that address.
- R5: If `POLL_LIMIT` reads in a row all return bit 5 clear, open finishes with `timeout_o` set. It issues no status write and makes no further reads.
- R6: A close begins with one read of the access register. If bit 5 is clear, it finishes with no write and no timeout.
- R7: If that read shows bit 5 set, close writes 0x0000_0020 to the access register. It then reads the register until bit 5 reads 0 and finishes without a timeout.
- R8: If the release poll makes `POLL_LIMIT` reads that all show bit 5 still set, close finishes with `timeout_o` set.
- R9: `open_i` and `close_i` are ignored while `busy_o` is high. When both arrive together while idle, the open is carried out.
- R10: While `bus_req_o` is high and `bus_ack_i` is low, the request, address, write flag and write data hold steady. `bus_req_o` is only high while `busy_o` is high.
- R11: `done_o` is a single-cycle pulse, and `busy_o` is already low in that cycle. `timeout_o` is only ever high together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_i | input | 1 | Pulse: claim the locality |
| close_i | input | 1 | Pulse: release the locality |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address of the register |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | One-cycle acknowledge that completes the request |
| bus_rdata_i | input | 32 | Read data, valid with the acknowledge |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| timeout_o | output | 1 | Set with `done_o` when a wait ran out |

## Verification
The bench models the device register file. It grants or releases the locality only after a chosen number of polls, and acknowledges each transaction after a random latency. Both sides of the poll limit are covered: a grant or release on the very last permitted read, and one a single read too late.

- A design with an off-by-one poll counter either times out on a grant that arrived in time or makes one read too many.
- A design that skips the active-flag check on close writes to a locality it does not hold.
- A design that still sends the command-ready write after an open timeout shows a stray status write.

Command pulses sent mid-operation, and an open and a close sent together, expose a block that restarts or chains a second operation.

// File: rtl/loc_pkg.sv
package loc_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned WIN_STRIDE = 32'h1000;
  localparam int unsigned ACC_OFS    = 32'h000;
  localparam int unsigned STS_OFS    = 32'h018;

  localparam int unsigned ACC_REQ_BIT   = 1;
  localparam int unsigned ACC_ACT_BIT   = 5;
  localparam int unsigned ACC_VALID_BIT = 7;
  localparam int unsigned STS_RDY_BIT   = 6;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OP_REQ,
    S_OP_POLL,
    S_OP_GAP,
    S_OP_RDY,
    S_CL_CHK,
    S_CL_REL,
    S_CL_POLL,
    S_CL_GAP
  } loc_state_e;

  function automatic logic [31:0] win_addr(logic [31:0] base, int unsigned loc,
                                           int unsigned ofs);
    return base + 32'(loc * WIN_STRIDE) + 32'(ofs);
  endfunction

  function automatic logic [REG_W-1:0] bit_word(int unsigned b);
    logic [REG_W-1:0] w;
    w = '0;
    w[b] = 1'b1;
    return w;
  endfunction

  function automatic logic acc_active(logic [REG_W-1:0] w);
    return w[ACC_ACT_BIT];
  endfunction

endpackage

// File: rtl/loc_poll_timer.sv
module loc_poll_timer #(
  parameter int POLL_GAP   = 125,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic miss,
  output logic last_poll,
  output logic gap_done
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);

  logic [CNT_W-1:0] miss_cnt_q;
  logic [GAP_W-1:0] gap_cnt_q;
  logic             gap_run_q;

  assign last_poll = (miss_cnt_q == CNT_W'(POLL_LIMIT - 1));
  assign gap_done  = gap_run_q && (gap_cnt_q == GAP_W'(POLL_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_cnt_q <= '0;
    end else if (arm) begin
      miss_cnt_q <= '0;
    end else if (miss) begin
      miss_cnt_q <= miss_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_run_q <= 1'b0;
      gap_cnt_q <= '0;
    end else if (miss) begin
      gap_run_q <= 1'b1;
      gap_cnt_q <= '0;
    end else if (gap_run_q) begin
      if (gap_done) gap_run_q <= 1'b0;
      else          gap_cnt_q <= gap_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/loc_bus_map.sv
module loc_bus_map
  import loc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input  loc_state_e        state,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  wdata
);
  localparam logic [ADDR_W-1:0] ACC_A = ADDR_W'(win_addr(BASE_ADDR, 0, ACC_OFS));
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(win_addr(BASE_ADDR, 0, STS_OFS));

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = ACC_A;
    wdata = '0;
    case (state)
      S_OP_REQ: begin
        req = 1'b1; we = 1'b1; wdata = bit_word(ACC_REQ_BIT);
      end
      S_OP_POLL, S_CL_CHK, S_CL_POLL: begin
        req = 1'b1;
      end
      S_OP_RDY: begin
        req = 1'b1; we = 1'b1; addr = STS_A; wdata = bit_word(STS_RDY_BIT);
      end
      S_CL_REL: begin
        req = 1'b1; we = 1'b1; wdata = bit_word(ACC_ACT_BIT);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/loc_access_ctrl.sv
module loc_access_ctrl
  import loc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [31:0] BASE_ADDR  = 32'h0,
  parameter int          POLL_GAP   = 125,
  parameter int          POLL_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              close_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  loc_state_e state_q, state_d;

  logic bus_fin_w, hit_w, in_poll_w, poll_good_w, poll_bad_w;
  logic poll_miss_w, arm_w, last_poll_w, gap_done_w;
  logic fin_ok_w, fin_to_w;
  logic done_q, to_q;

  loc_bus_map #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_map (
    .state (state_q),
    .req   (bus_req_o),
    .we    (bus_we_o),
    .addr  (bus_addr_o),
    .wdata (bus_wdata_o)
  );

  loc_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm_w),
    .miss      (poll_miss_w),
    .last_poll (last_poll_w),
    .gap_done  (gap_done_w)
  );

  assign bus_fin_w   = bus_req_o & bus_ack_i;
  assign hit_w       = acc_active(bus_rdata_i);
  assign in_poll_w   = (state_q == S_OP_POLL) || (state_q == S_CL_POLL);
  assign poll_good_w = in_poll_w && bus_fin_w &&
                       ((state_q == S_OP_POLL) ? hit_w : !hit_w);
  assign poll_bad_w  = in_poll_w && bus_fin_w && !poll_good_w;
  assign fin_to_w    = poll_bad_w && last_poll_w;
  assign poll_miss_w = poll_bad_w && !last_poll_w;
  assign arm_w       = bus_fin_w && ((state_q == S_OP_REQ) || (state_q == S_CL_REL));
  assign fin_ok_w    = bus_fin_w && ((state_q == S_OP_RDY) ||
                                     ((state_q == S_CL_CHK) && !hit_w) ||
                                     ((state_q == S_CL_POLL) && !hit_w));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (open_i)       state_d = S_OP_REQ;
        else if (close_i) state_d = S_CL_CHK;
      end
      S_OP_REQ:  if (bus_fin_w) state_d = S_OP_POLL;
      S_OP_POLL: begin
        if (poll_good_w)      state_d = S_OP_RDY;
        else if (fin_to_w)    state_d = S_IDLE;
        else if (poll_miss_w) state_d = S_OP_GAP;
      end
      S_OP_GAP:  if (gap_done_w) state_d = S_OP_POLL;
      S_OP_RDY:  if (bus_fin_w) state_d = S_IDLE;
      S_CL_CHK:  if (bus_fin_w) state_d = hit_w ? S_CL_REL : S_IDLE;
      S_CL_REL:  if (bus_fin_w) state_d = S_CL_POLL;
      S_CL_POLL: begin
        if (poll_good_w || fin_to_w) state_d = S_IDLE;
        else if (poll_miss_w)        state_d = S_CL_GAP;
      end
      S_CL_GAP:  if (gap_done_w) state_d = S_CL_POLL;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok_w | fin_to_w;
      to_q    <= fin_to_w;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/loc_access_chk.sv
module loc_access_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter int          GAP       = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              open_i,
  input logic              close_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              poll_miss
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(BASE_ADDR + 32'h18);
  localparam int GW = $clog2(GAP + 2) + 1;

  logic [GW-1:0] since_miss_q;
  logic          gap_armed_q;
  logic          req_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_miss_q <= '0;
      gap_armed_q  <= 1'b0;
      req_prev_q   <= 1'b0;
    end else begin
      req_prev_q <= bus_req_o;
      if (poll_miss) begin
        since_miss_q <= '0;
        gap_armed_q  <= 1'b1;
      end else begin
        if (since_miss_q != '1) since_miss_q <= since_miss_q + 1'b1;
        if (bus_req_o && !req_prev_q) gap_armed_q <= 1'b0;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));
  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> busy_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);
  // R11
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> done_o);
  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && (open_i || close_i) |=> busy_o);
  // R3
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !req_prev_q && gap_armed_q |-> since_miss_q >= GW'(GAP));
  // R4
  ready_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_addr_o == STS_A |-> bus_we_o && bus_wdata_o == 32'h40);
endmodule

bind loc_access_ctrl loc_access_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .GAP(POLL_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .open_i(open_i), .close_i(close_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o), .poll_miss(poll_miss_w)
);

// File: tb/tb_loc_access_ctrl.sv
module tb_loc_access_ctrl;
  localparam int GAP   = 4;
  localparam int LIMIT = 8;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          open_i = 1'b0, close_i = 1'b0;
  logic          bus_req_o, bus_we_o, busy_o, done_o, timeout_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0]   bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [31:0]   bus_rdata_i = '0;

  always #4 clk = ~clk;

  loc_access_ctrl #(.ADDR_W(AW), .BASE_ADDR(32'h0), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .open_i(open_i), .close_i(close_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  int checks = 0, fails = 0;
  // device model
  bit dev_active = 0, pend_grant = 0, pend_rel = 0;
  int grant_k = 0, rel_k = 0, rd_seen = 0, lat = 0, wait_cnt = 0;
  // transaction log
  int n_acc_wr = 0, n_acc_rd = 0, n_sts_wr = 0, n_bad = 0;
  logic [31:0] acc_wr_val = '0, sts_wr_val = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_acc_wr = 0; n_acc_rd = 0; n_sts_wr = 0; n_bad = 0;
    acc_wr_val = '0; sts_wr_val = '0;
  endtask

  // responder: drives at negedge, away from the active edge
  always @(negedge clk) begin
    if (bus_ack_i) begin
      bus_ack_i <= 1'b0;
    end else if (bus_req_o) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        if (bus_addr_o == 16'h0000 && bus_we_o) begin
          n_acc_wr++; acc_wr_val = bus_wdata_o;
          if (bus_wdata_o[1] && !dev_active) begin pend_grant = 1; rd_seen = 0; end
          if (bus_wdata_o[5] && dev_active)  begin pend_rel = 1;   rd_seen = 0; end
        end else if (bus_addr_o == 16'h0000) begin
          n_acc_rd++;
          if (pend_grant) begin
            if (rd_seen == grant_k) begin dev_active = 1; pend_grant = 0; end
            else rd_seen++;
          end else if (pend_rel) begin
            if (rd_seen == rel_k) begin dev_active = 0; pend_rel = 0; end
            else rd_seen++;
          end
        end else if (bus_addr_o == 16'h0018 && bus_we_o) begin
          n_sts_wr++; sts_wr_val = bus_wdata_o;
        end else begin
          n_bad++;
        end
        bus_rdata_i <= 32'h80 | (dev_active ? 32'h20 : 32'h0);
        bus_ack_i   <= 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  function automatic int exp_polls(int k);
    return (k < LIMIT) ? k + 1 : LIMIT;
  endfunction

  logic got_to;

  task automatic wait_done(string req);
    int n = 0;
    got_to = 1'b0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    if (!done_o) begin
      checks++; fails++;
      $display("FAIL %s: watchdog, actual no done expected done", req);
    end else begin
      got_to = timeout_o;
      chk({req, "/R11 busy low with done"}, 32'(busy_o), 0);
      @(negedge clk);
      chk({req, "/R11 done single cycle"}, 32'(done_o), 0);
      chk({req, "/R11 timeout cleared"}, 32'(timeout_o), 0);
    end
  endtask

  task automatic do_open(int k, int l);
    clear_log(); dev_active = 0; pend_grant = 0; pend_rel = 0;
    grant_k = k; lat = l;
    @(negedge clk); open_i = 1; @(negedge clk); open_i = 0;
    wait_done("open");
    chk("R2 request write count", n_acc_wr, 1);
    chk("R2 request word", acc_wr_val, 32'h2);
    chk("R3 poll read count", n_acc_rd, exp_polls(k));
    chk("R4 R5 status write count", n_sts_wr, (k < LIMIT) ? 1 : 0);
    if (k < LIMIT) chk("R4 ready word", sts_wr_val, 32'h40);
    chk("R5 timeout flag", 32'(got_to), (k >= LIMIT) ? 1 : 0);
    chk("R2 stray address", n_bad, 0);
  endtask

  task automatic do_close(bit act, int k, int l);
    clear_log(); dev_active = act; pend_grant = 0; pend_rel = 0;
    rel_k = k; lat = l;
    @(negedge clk); close_i = 1; @(negedge clk); close_i = 0;
    wait_done("close");
    if (!act) begin
      chk("R6 no release write", n_acc_wr, 0);
      chk("R6 single check read", n_acc_rd, 1);
      chk("R6 no timeout", 32'(got_to), 0);
    end else begin
      chk("R7 release write count", n_acc_wr, 1);
      chk("R7 release word", acc_wr_val, 32'h20);
      chk("R7 R8 read count", n_acc_rd, 1 + exp_polls(k));
      chk("R8 timeout flag", 32'(got_to), (k >= LIMIT) ? 1 : 0);
    end
    chk("R6 status untouched", n_sts_wr, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state and quiet bus
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 timeout", 32'(timeout_o), 0);
    chk("R1 req", 32'(bus_req_o), 0);
    chk("R1 no traffic", n_acc_rd + n_acc_wr + n_sts_wr, 0);

    // directed corners around the poll limit
    do_open(0, 0);
    do_open(LIMIT - 1, 1);
    do_open(LIMIT, 0);
    do_close(0, 0, 2);
    do_close(1, LIMIT - 1, 0);
    do_close(1, LIMIT, 1);

    // R9 pulses while busy are ignored
    clear_log(); dev_active = 0; pend_rel = 0; grant_k = 3; lat = 1;
    @(negedge clk); open_i = 1; @(negedge clk); open_i = 0;
    repeat (3) @(negedge clk);
    close_i = 1; open_i = 1; @(negedge clk); close_i = 0; open_i = 0;
    wait_done("R9 busy");
    chk("R9 one request write only", n_acc_wr, 1);
    chk("R9 reads of one open", n_acc_rd, 4);
    clear_log();
    repeat (12) @(negedge clk);
    chk("R9 nothing chained", n_acc_rd + n_acc_wr + n_sts_wr, 0);
    chk("R9 idle after", 32'(busy_o), 0);

    // R9 simultaneous open and close while idle: open wins
    clear_log(); dev_active = 0; grant_k = 1; lat = 0;
    @(negedge clk); open_i = 1; close_i = 1; @(negedge clk); open_i = 0; close_i = 0;
    wait_done("R9 both");
    chk("R9 open chosen", acc_wr_val, 32'h2);
    chk("R9 open ready write", n_sts_wr, 1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int k = $urandom_range(LIMIT + 2, 0);
      int l = $urandom_range(2, 0);
      if ($urandom_range(1, 0) == 1) do_open(k, l);
      else do_close(1'($urandom_range(1, 0)), k, l);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule